// File: doc/BRIEF.md
# Tagged Multi-Size Translation Cache

This block is a small fully associative cache of completed page-table walks for a three-level, 39-bit virtual address scheme. Every slot holds one mapping together with its address-space tag, a global marker, a copy of the page-table entry and the physical address that entry was read from. The page size of a slot comes from the level at which the walk ended: level 0 maps a 4 KiB page, level 1 a 2 MiB page and level 2 a 1 GiB page.

When a walk result is written in, the block derives two masks from the level. One keeps the page-number bits that take part in matching. The other keeps the offset bits that are passed straight through to the physical address. The stored virtual tag and the physical base are trimmed to the page boundary at that time. A lookup is purely combinational on the current contents. It returns the translated address, the stored entry and the slot index, so that a later permission-bit update can rewrite that entry in place.

Invalidation takes an optional address-space tag and an optional address, and applies one of four rules depending on which of the two are given. Global mappings are immune to any invalidation that names an address-space tag.

Top module: `sptlb_top`

## Requirements
- R1: While reset is high and after it is released, the cache holds no mapping and every lookup reports a miss.
- R2: A lookup hits a slot when the slot is valid, its virtual tag equals the lookup address with the slot's offset bits cleared, and either its tag matches the lookup tag or it is global. A non-global mapping does not hit under a different tag. On a hit, the physical address is the stored base ORed with the lookup address's offset bits, and the stored entry and slot index are returned.
- R3: The offset width is 12 + 9 × level bits. It is 12, 21 or 30 for levels 0, 1 and 2. The stored base and virtual tag are cleared below that width. An address just outside the covered range misses.
- R4: A global mapping hits under any lookup tag.
- R5: An insert fills the lowest-numbered empty slot. When no slot is empty, it replaces the slot with the smallest insertion stamp, which comes from a free-running cycle counter. The slot used is reported as the lookup index on later hits.
- R6: An entry rewrite by slot index replaces only that slot's stored page-table entry. The mapping and its validity are unchanged.
- R7: An invalidation with neither a tag nor an address empties every slot.
- R8: An invalidation with only an address removes every slot that matches the address under its own mask, global or not and whatever its tag. Other slots are kept.
- R9: An invalidation with only a tag removes the non-global slots carrying that tag. Global slots and other tags are kept.
- R10: An invalidation with both a tag and an address removes only non-global slots that match on both.
- R11: When several operations are requested in one cycle, invalidation runs and insert and rewrite are dropped. Otherwise insert runs and rewrite is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_asid | input | 16 | Address-space tag of the lookup |
| lk_vaddr | input | 39 | Virtual address of the lookup |
| lk_hit | output | 1 | Lookup found a mapping |
| lk_idx | output | IDX_W (2) | Slot index of the hit |
| lk_paddr | output | 56 | Translated physical address |
| lk_pte | output | 64 | Stored page-table entry of the hit |
| lk_pte_addr | output | 56 | Physical address of that entry |
| lk_global | output | 1 | Hit slot is global |
| ins_en | input | 1 | Insert a walk result |
| ins_asid | input | 16 | Tag of the new mapping |
| ins_global | input | 1 | New mapping is global |
| ins_vaddr | input | 39 | Virtual address that was walked |
| ins_paddr | input | 56 | Physical address produced by the walk |
| ins_level | input | 2 | Level at which the walk ended (0 to 2) |
| ins_pte | input | 64 | Leaf page-table entry |
| ins_pte_addr | input | 56 | Physical address of the leaf entry |
| wr_en | input | 1 | Rewrite a stored entry |
| wr_idx | input | IDX_W (2) | Slot to rewrite |
| wr_pte | input | 64 | New page-table entry value |
| fl_en | input | 1 | Invalidate |
| fl_use_asid | input | 1 | Invalidation names a tag |
| fl_asid | input | 16 | Tag for the invalidation |
| fl_use_addr | input | 1 | Invalidation names an address |
| fl_vaddr | input | 39 | Address for the invalidation |

## Verification
The assertions assume that the insert level is never above 2, and they check this as an input rule. They also assume that the rewrite index names an existing slot. The stimulus only uses levels 0, 1 and 2, and only rewrites slot indices that an earlier lookup returned. The assertions further assume that the cycle counter does not wrap while a stamp is still compared. The runs are far shorter than 2^32 cycles, so the oldest slot always carries the smallest stamp.

// File: rtl/sptlb_pkg.sv
package sptlb_pkg;

    localparam int VA_W     = 39;
    localparam int PA_W     = 56;
    localparam int ASID_W   = 16;
    localparam int PTE_W    = 64;
    localparam int PTEA_W   = 56;
    localparam int OFS_W    = 12;
    localparam int LVL_STEP = 9;
    localparam int LEVELS   = 3;
    localparam int LVL_W    = 2;
    localparam int AGE_W    = 32;

    typedef struct packed {
        logic              valid;
        logic              global;
        logic [ASID_W-1:0] asid;
        logic [VA_W-1:0]   vtag;
        logic [VA_W-1:0]   vmatch;
        logic [VA_W-1:0]   voff;
        logic [PA_W-1:0]   pbase;
        logic [PTE_W-1:0]  pte;
        logic [PTEA_W-1:0] pte_addr;
        logic [AGE_W-1:0]  stamp;
    } tlb_ent_t;

    typedef enum logic [1:0] {
        KILL_ALL  = 2'b00,
        KILL_ADDR = 2'b01,
        KILL_TAG  = 2'b10,
        KILL_BOTH = 2'b11
    } kill_kind_t;

    // Offset width for a walk that ended at the given level.
    function automatic int unsigned lvl_shift(input logic [LVL_W-1:0] lvl);
        return OFS_W + int'(lvl) * LVL_STEP;
    endfunction

    // Ones in the offset bits of a virtual address.
    function automatic logic [VA_W-1:0] va_off_mask(input logic [LVL_W-1:0] lvl);
        logic [VA_W-1:0] ones;
        ones = '1;
        return ~(ones << lvl_shift(lvl));
    endfunction

    // Ones in the page-number bits of a physical address.
    function automatic logic [PA_W-1:0] pa_page_mask(input logic [LVL_W-1:0] lvl);
        logic [PA_W-1:0] ones;
        ones = '1;
        return ones << lvl_shift(lvl);
    endfunction

endpackage

// File: rtl/sptlb_slot_cmp.sv
module sptlb_slot_cmp
    import sptlb_pkg::*;
(
    input  logic              valid,
    input  logic              global,
    input  logic [ASID_W-1:0] asid,
    input  logic [VA_W-1:0]   vtag,
    input  logic [VA_W-1:0]   vmatch,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic              fl_use_asid,
    input  logic              fl_use_addr,
    input  logic [ASID_W-1:0] fl_asid,
    input  logic [VA_W-1:0]   fl_vaddr,
    output logic              hit,
    output logic              kill
);
    logic       tag_ok, page_ok, fl_tag_eq, fl_page_eq;
    kill_kind_t kind;

    assign tag_ok     = global || (asid == lk_asid);
    assign page_ok    = (lk_vaddr & vmatch) == vtag;
    assign hit        = valid && tag_ok && page_ok;

    assign fl_tag_eq  = (asid == fl_asid);
    assign fl_page_eq = (fl_vaddr & vmatch) == vtag;
    assign kind       = kill_kind_t'({fl_use_asid, fl_use_addr});

    always_comb begin
        unique case (kind)
            KILL_ALL:  kill = valid;
            KILL_ADDR: kill = valid && fl_page_eq;
            KILL_TAG:  kill = valid && !global && fl_tag_eq;
            KILL_BOTH: kill = valid && !global && fl_tag_eq && fl_page_eq;
            default:   kill = 1'b0;
        endcase
    end
endmodule

// File: rtl/sptlb_victim.sv
module sptlb_victim
    import sptlb_pkg::*;
#(
    parameter int ENTRIES = 4,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0]            valid,
    input  logic [ENTRIES-1:0][AGE_W-1:0] stamps,
    output logic [IDX_W-1:0]              victim
);
    always_comb begin
        logic found;
        int   best;
        victim = '0;
        found  = 1'b0;
        best   = 0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!valid[i] && !found) begin
                victim = IDX_W'(i);
                found  = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 1; i < ENTRIES; i++) begin
                if (stamps[i] < stamps[best]) best = i;
            end
            victim = IDX_W'(best);
        end
    end
endmodule

// File: rtl/sptlb_hit_sel.sv
module sptlb_hit_sel #(
    parameter int ENTRIES = 4,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0] hits,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);
    // Lowest-numbered hit wins when mappings overlap.
    always_comb begin
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hits[i]) idx = IDX_W'(i);
        end
    end
    assign any = |hits;
endmodule

// File: rtl/sptlb_top.sv
module sptlb_top
    import sptlb_pkg::*;
#(
    parameter int ENTRIES = 4,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VA_W-1:0]   lk_vaddr,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [PA_W-1:0]   lk_paddr,
    output logic [PTE_W-1:0]  lk_pte,
    output logic [PTEA_W-1:0] lk_pte_addr,
    output logic              lk_global,
    input  logic              ins_en,
    input  logic [ASID_W-1:0] ins_asid,
    input  logic              ins_global,
    input  logic [VA_W-1:0]   ins_vaddr,
    input  logic [PA_W-1:0]   ins_paddr,
    input  logic [LVL_W-1:0]  ins_level,
    input  logic [PTE_W-1:0]  ins_pte,
    input  logic [PTEA_W-1:0] ins_pte_addr,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [PTE_W-1:0]  wr_pte,
    input  logic              fl_en,
    input  logic              fl_use_asid,
    input  logic [ASID_W-1:0] fl_asid,
    input  logic              fl_use_addr,
    input  logic [VA_W-1:0]   fl_vaddr
);
    tlb_ent_t [ENTRIES-1:0]            tab;
    logic     [ENTRIES-1:0]            valid_vec, hits, kills;
    logic     [ENTRIES-1:0][AGE_W-1:0] stamps;
    logic     [IDX_W-1:0]              victim;
    logic     [AGE_W-1:0]              tick;
    tlb_ent_t                          fresh, sel;

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_slot
            assign valid_vec[g] = tab[g].valid;
            assign stamps[g]    = tab[g].stamp;

            sptlb_slot_cmp u_cmp (
                .valid       (tab[g].valid),
                .global      (tab[g].global),
                .asid        (tab[g].asid),
                .vtag        (tab[g].vtag),
                .vmatch      (tab[g].vmatch),
                .lk_asid     (lk_asid),
                .lk_vaddr    (lk_vaddr),
                .fl_use_asid (fl_use_asid),
                .fl_use_addr (fl_use_addr),
                .fl_asid     (fl_asid),
                .fl_vaddr    (fl_vaddr),
                .hit         (hits[g]),
                .kill        (kills[g])
            );

            // R9: a tag-qualified invalidation never removes a global slot
            a_r9_global_kept: assert property (@(posedge clk) disable iff (rst)
                fl_en && fl_use_asid && tab[g].valid && tab[g].global |=> tab[g].valid);

            // R3: a valid slot's base has no bits inside its offset range
            a_r3_base_trimmed: assert property (@(posedge clk) disable iff (rst)
                tab[g].valid |-> (tab[g].pbase & PA_W'(tab[g].voff)) == '0);
        end
    endgenerate

    sptlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .valid  (valid_vec),
        .stamps (stamps),
        .victim (victim)
    );

    sptlb_hit_sel #(.ENTRIES(ENTRIES)) u_sel (
        .hits (hits),
        .any  (lk_hit),
        .idx  (lk_idx)
    );

    // Build the slot image for an incoming walk result.
    always_comb begin
        fresh          = '0;
        fresh.valid    = 1'b1;
        fresh.global   = ins_global;
        fresh.asid     = ins_asid;
        fresh.voff     = va_off_mask(ins_level);
        fresh.vmatch   = ~va_off_mask(ins_level);
        fresh.vtag     = ins_vaddr & ~va_off_mask(ins_level);
        fresh.pbase    = ins_paddr & pa_page_mask(ins_level);
        fresh.pte      = ins_pte;
        fresh.pte_addr = ins_pte_addr;
        fresh.stamp    = tick;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tick <= '0;
            tab  <= '0;
        end else begin
            tick <= tick + 1'b1;
            if (fl_en) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (kills[i]) tab[i].valid <= 1'b0;
                end
            end else if (ins_en) begin
                tab[victim] <= fresh;
            end else if (wr_en && (int'(wr_idx) < ENTRIES)) begin
                tab[wr_idx].pte <= wr_pte;
            end
        end
    end

    assign sel         = tab[lk_idx];
    assign lk_paddr    = lk_hit ? (sel.pbase | PA_W'(lk_vaddr & sel.voff)) : '0;
    assign lk_pte      = lk_hit ? sel.pte : '0;
    assign lk_pte_addr = lk_hit ? sel.pte_addr : '0;
    assign lk_global   = lk_hit && sel.global;

    // R3: only levels 0..2 may be inserted
    a_r3_level_legal: assert property (@(posedge clk) disable iff (rst)
        ins_en |-> ins_level < LVL_W'(LEVELS));

    // R7: unqualified invalidation leaves nothing behind
    a_r7_all_gone: assert property (@(posedge clk) disable iff (rst)
        fl_en && !fl_use_asid && !fl_use_addr |=> valid_vec == '0);

    // R11: an invalidation cycle never adds a slot
    a_r11_flush_wins: assert property (@(posedge clk) disable iff (rst)
        fl_en |=> $countones(valid_vec) <= $past($countones(valid_vec)));

    // R6: a rewrite alone leaves every slot's validity unchanged
    a_r6_rewrite_keeps: assert property (@(posedge clk) disable iff (rst)
        wr_en && !fl_en && !ins_en |=> $stable(valid_vec));

    // R5: an empty slot is always chosen ahead of an occupied one
    a_r5_victim_empty: assert property (@(posedge clk) disable iff (rst)
        !(&valid_vec) |-> !valid_vec[victim]);

    // R2: the reported index points at a valid slot
    a_r2_idx_valid: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> valid_vec[lk_idx]);

    // R1: nothing is held right after reset
    a_r1_empty_after_reset: assert property (@(posedge clk)
        $past(rst) |-> valid_vec == '0);
endmodule

// File: tb/sptlb_top_test.sv
`timescale 1ns/1ps
module sptlb_top_test;
    import sptlb_pkg::*;

    localparam int IDX_W = 2;

    typedef enum logic [1:0] {OP_INS, OP_LK, OP_FL, OP_WR} op_t;

    // For lookups, pa holds the expected physical address and pte the expected entry.
    typedef struct packed {
        op_t         op;
        logic [3:0]  req;
        logic [15:0] asid;
        logic        glb;
        logic        ua;
        logic        uv;
        logic [38:0] va;
        logic [55:0] pa;
        logic [1:0]  lvl;
        logic [63:0] pte;
        logic        hit;
        logic [1:0]  idx;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t TABLE [NV] = '{
        '{OP_INS, 4'd2,  16'd1, 1'b0, 1'b0, 1'b0, 39'h00_0040_1234, 56'h8_0000_5000, 2'd0, 64'hA1, 1'b0, 2'd0},
        '{OP_LK,  4'd2,  16'd1, 1'b0, 1'b0, 1'b0, 39'h00_0040_1ABC, 56'h8_0000_5ABC, 2'd0, 64'hA1, 1'b1, 2'd0}, // R2
        '{OP_LK,  4'd2,  16'd2, 1'b0, 1'b0, 1'b0, 39'h00_0040_1ABC, 56'h0,           2'd0, 64'h0,  1'b0, 2'd0}, // R2 tag mismatch
        '{OP_INS, 4'd3,  16'd2, 1'b1, 1'b0, 1'b0, 39'h00_8012_3456, 56'h1_2345_6789, 2'd1, 64'hB1, 1'b0, 2'd0},
        '{OP_LK,  4'd4,  16'd7, 1'b0, 1'b0, 1'b0, 39'h00_801F_FFF0, 56'h1_235F_FFF0, 2'd0, 64'hB1, 1'b1, 2'd1}, // R3 R4
        '{OP_LK,  4'd3,  16'd2, 1'b0, 1'b0, 1'b0, 39'h00_8020_0000, 56'h0,           2'd0, 64'h0,  1'b0, 2'd0}, // R3 edge
        '{OP_INS, 4'd3,  16'd1, 1'b0, 1'b0, 1'b0, 39'h40_1234_5678, 56'h0_C000_0000, 2'd2, 64'hC1, 1'b0, 2'd0},
        '{OP_LK,  4'd3,  16'd1, 1'b0, 1'b0, 1'b0, 39'h40_3FFF_FFFF, 56'h0_FFFF_FFFF, 2'd0, 64'hC1, 1'b1, 2'd2}, // R3 1 GiB
        '{OP_WR,  4'd6,  16'd0, 1'b0, 1'b0, 1'b0, 39'h0,            56'h0,           2'd0, 64'hC2, 1'b0, 2'd2},
        '{OP_LK,  4'd6,  16'd1, 1'b0, 1'b0, 1'b0, 39'h40_0000_0010, 56'h0_C000_0010, 2'd0, 64'hC2, 1'b1, 2'd2}, // R6
        '{OP_INS, 4'd5,  16'd3, 1'b0, 1'b0, 1'b0, 39'h7F_FFFF_F000, 56'hFF_FFFF_F000, 2'd0, 64'hD1, 1'b0, 2'd0},
        '{OP_LK,  4'd5,  16'd3, 1'b0, 1'b0, 1'b0, 39'h7F_FFFF_FFFF, 56'hFF_FFFF_FFFF, 2'd0, 64'hD1, 1'b1, 2'd3}, // R5
        '{OP_INS, 4'd5,  16'd4, 1'b0, 1'b0, 1'b0, 39'h00_0000_1000, 56'h0_0000_2000, 2'd0, 64'hE1, 1'b0, 2'd0},
        '{OP_LK,  4'd5,  16'd1, 1'b0, 1'b0, 1'b0, 39'h00_0040_1ABC, 56'h0,           2'd0, 64'h0,  1'b0, 2'd0}, // R5 oldest evicted
        '{OP_LK,  4'd5,  16'd4, 1'b0, 1'b0, 1'b0, 39'h00_0000_1008, 56'h0_0000_2008, 2'd0, 64'hE1, 1'b1, 2'd0}, // R5
        '{OP_FL,  4'd9,  16'd2, 1'b0, 1'b1, 1'b0, 39'h0,            56'h0,           2'd0, 64'h0,  1'b0, 2'd0},
        '{OP_LK,  4'd9,  16'd9, 1'b0, 1'b0, 1'b0, 39'h00_8000_0000, 56'h1_2340_0000, 2'd0, 64'hB1, 1'b1, 2'd1}, // R9 global kept
        '{OP_FL,  4'd9,  16'd4, 1'b0, 1'b1, 1'b0, 39'h0,            56'h0,           2'd0, 64'h0,  1'b0, 2'd0},
        '{OP_LK,  4'd9,  16'd4, 1'b0, 1'b0, 1'b0, 39'h00_0000_1008, 56'h0,           2'd0, 64'h0,  1'b0, 2'd0}, // R9 removed
        '{OP_FL,  4'd10, 16'd5, 1'b0, 1'b1, 1'b1, 39'h40_0000_0000, 56'h0,           2'd0, 64'h0,  1'b0, 2'd0},
        '{OP_LK,  4'd10, 16'd1, 1'b0, 1'b0, 1'b0, 39'h40_0000_0010, 56'h0_C000_0010, 2'd0, 64'hC2, 1'b1, 2'd2}, // R10 other tag kept
        '{OP_FL,  4'd10, 16'd3, 1'b0, 1'b1, 1'b1, 39'h7F_FFFF_F123, 56'h0,           2'd0, 64'h0,  1'b0, 2'd0},
        '{OP_LK,  4'd10, 16'd3, 1'b0, 1'b0, 1'b0, 39'h7F_FFFF_FFFF, 56'h0,           2'd0, 64'h0,  1'b0, 2'd0}, // R10 removed
        '{OP_FL,  4'd8,  16'd0, 1'b0, 1'b0, 1'b1, 39'h00_8000_1000, 56'h0,           2'd0, 64'h0,  1'b0, 2'd0},
        '{OP_LK,  4'd8,  16'd2, 1'b0, 1'b0, 1'b0, 39'h00_8000_0000, 56'h0,           2'd0, 64'h0,  1'b0, 2'd0}, // R8 global removed
        '{OP_LK,  4'd8,  16'd1, 1'b0, 1'b0, 1'b0, 39'h40_0000_0010, 56'h0_C000_0010, 2'd0, 64'hC2, 1'b1, 2'd2}, // R8 others kept
        '{OP_FL,  4'd7,  16'd0, 1'b0, 1'b0, 1'b0, 39'h0,            56'h0,           2'd0, 64'h0,  1'b0, 2'd0},
        '{OP_LK,  4'd7,  16'd1, 1'b0, 1'b0, 1'b0, 39'h40_0000_0010, 56'h0,           2'd0, 64'h0,  1'b0, 2'd0}  // R7
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [15:0]       lk_asid = '0;
    logic [38:0]       lk_vaddr = '0;
    logic              lk_hit;
    logic [IDX_W-1:0]  lk_idx;
    logic [55:0]       lk_paddr;
    logic [63:0]       lk_pte;
    logic [55:0]       lk_pte_addr;
    logic              lk_global;
    logic              ins_en = 1'b0;
    logic [15:0]       ins_asid = '0;
    logic              ins_global = 1'b0;
    logic [38:0]       ins_vaddr = '0;
    logic [55:0]       ins_paddr = '0;
    logic [1:0]        ins_level = '0;
    logic [63:0]       ins_pte = '0;
    logic [55:0]       ins_pte_addr = '0;
    logic              wr_en = 1'b0;
    logic [IDX_W-1:0]  wr_idx = '0;
    logic [63:0]       wr_pte = '0;
    logic              fl_en = 1'b0;
    logic              fl_use_asid = 1'b0;
    logic [15:0]       fl_asid = '0;
    logic              fl_use_addr = 1'b0;
    logic [38:0]       fl_vaddr = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    sptlb_top uut (
        .clk(clk), .rst(rst),
        .lk_asid(lk_asid), .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_idx(lk_idx),
        .lk_paddr(lk_paddr), .lk_pte(lk_pte), .lk_pte_addr(lk_pte_addr), .lk_global(lk_global),
        .ins_en(ins_en), .ins_asid(ins_asid), .ins_global(ins_global), .ins_vaddr(ins_vaddr),
        .ins_paddr(ins_paddr), .ins_level(ins_level), .ins_pte(ins_pte), .ins_pte_addr(ins_pte_addr),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_pte(wr_pte),
        .fl_en(fl_en), .fl_use_asid(fl_use_asid), .fl_asid(fl_asid),
        .fl_use_addr(fl_use_addr), .fl_vaddr(fl_vaddr)
    );

    task automatic idle_all();
        ins_en = 1'b0; wr_en = 1'b0; fl_en = 1'b0;
    endtask

    // Lookup check: called after inputs settle, away from the clock edge.
    task automatic check_lk(input int req, input logic [15:0] asid, input logic [38:0] va,
                            input logic ehit, input logic [1:0] eidx,
                            input logic [55:0] epa, input logic [63:0] epte);
        lk_asid  = asid;
        lk_vaddr = va;
        #1;
        checks++;
        if (lk_hit !== ehit ||
            (ehit && (lk_idx !== eidx || lk_paddr !== epa || lk_pte !== epte))) begin
            fails++;
            $display("FAIL R%0d: hit=%0b idx=%0d pa=%h pte=%h expected hit=%0b idx=%0d pa=%h pte=%h",
                     req, lk_hit, lk_idx, lk_paddr, lk_pte, ehit, eidx, epa, epte);
        end
    endtask

    task automatic run_vec(input vec_t v);
        @(negedge clk);
        idle_all();
        case (v.op)
            OP_INS: begin
                ins_en = 1'b1; ins_asid = v.asid; ins_global = v.glb;
                ins_vaddr = v.va; ins_paddr = v.pa; ins_level = v.lvl;
                ins_pte = v.pte; ins_pte_addr = 56'h100 + 56'(v.pte);
            end
            OP_WR: begin
                wr_en = 1'b1; wr_idx = v.idx; wr_pte = v.pte;
            end
            OP_FL: begin
                fl_en = 1'b1; fl_use_asid = v.ua; fl_asid = v.asid;
                fl_use_addr = v.uv; fl_vaddr = v.va;
            end
            default: check_lk(int'(v.req), v.asid, v.va, v.hit, v.idx, v.pa, v.pte);
        endcase
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // R1: lookup during reset misses
        @(negedge clk);
        check_lk(1, 16'd0, 39'h0, 1'b0, 2'd0, 56'h0, 64'h0);
        rst = 1'b0;
        @(negedge clk);
        // R1: lookup after reset misses
        check_lk(1, 16'd1, 39'h40_0000_0000, 1'b0, 2'd0, 56'h0, 64'h0);

        for (int i = 0; i < NV; i++) run_vec(TABLE[i]);

        // R11: insert in the same cycle as an invalidation is dropped
        @(negedge clk);
        idle_all();
        ins_en = 1'b1; ins_asid = 16'd6; ins_global = 1'b0; ins_vaddr = 39'h00_0000_3000;
        ins_paddr = 56'h0_0000_9000; ins_level = 2'd0; ins_pte = 64'hF1; ins_pte_addr = 56'h200;
        fl_en = 1'b1; fl_use_asid = 1'b1; fl_asid = 16'd99; fl_use_addr = 1'b0;
        @(negedge clk);
        idle_all();
        check_lk(11, 16'd6, 39'h00_0000_3004, 1'b0, 2'd0, 56'h0, 64'h0);

        // R11 and R5: insert beats a same-cycle rewrite; empty table fills slot 0
        @(negedge clk);
        idle_all();
        ins_en = 1'b1;
        wr_en = 1'b1; wr_idx = 2'd0; wr_pte = 64'hBAD;
        @(negedge clk);
        idle_all();
        check_lk(11, 16'd6, 39'h00_0000_3004, 1'b1, 2'd0, 56'h0_0000_9004, 64'hF1);

        // R5: next insert takes the lowest empty slot (1)
        @(negedge clk);
        ins_en = 1'b1; ins_asid = 16'd6; ins_vaddr = 39'h00_0000_5000;
        ins_paddr = 56'h0_0000_7000; ins_pte = 64'hF2;
        @(negedge clk);
        idle_all();
        check_lk(5, 16'd6, 39'h00_0000_5FFF, 1'b1, 2'd1, 56'h0_0000_7FFF, 64'hF2);

        // R2: stored entry address is returned on a hit
        checks++;
        if (lk_pte_addr !== 56'h200) begin
            fails++;
            $display("FAIL R2: pte_addr=%h expected %h", lk_pte_addr, 56'h200);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule